// File: doc/BRIEF.md
# Descriptor ring pointer bank

This block holds the pointer state for a set of circular descriptor queues used by a DMA engine. Each queue has a base address, a length in descriptors, a producer index and a consumer index. Software reaches them through a simple register write port and a combinational read port. The DMA side pulses one-cycle advance strobes and reads back the memory address of the current producer and consumer descriptors.

Pointers are exposed to software as byte offsets into the ring. Each descriptor is 32 bytes. The ring length is exchanged as the descriptor count multiplied by eight. A queue reports empty when both indices match. It reports full when only one slot is left unused, so the full and empty conditions never look alike. Base address and length are guarded: a write to either lands only while its own permit bit is set in the queue's permit register.

The bank has four queues by default. The first two are receive rings with 64 descriptors and the last two are transmit rings with 2. The queue count, the data width and the default depths are parameters.

Top module: `ring_ptr_bank`

## Requirements
- R1: After reset, every base address is 0, every index is 0, every permit bit is 0, every error flag is 0 and every queue is empty. The length reads back as 64<<3 for the first two queues and 2<<3 for the others.
- R2: Queue q occupies the 32-byte window starting at q*0x20, and reg_addr[4:0] selects the register within it. 0x00 is the base address, 0x04 the length, 0x08 the producer pointer, 0x0C the consumer pointer and 0x18 the permit register. In the permit register, bit 2 guards the base address and bit 1 guards the length. Every other offset reads 0, and writes to it change nothing.
- R3: A write to the base address is ignored unless permit bit 2 of that queue is set.
- R4: A length write takes the count from wdata[9:3] and reads back as count<<3. It is ignored unless permit bit 1 is set; permit bit 2 alone does not allow it.
- R5: A pointer write stores the descriptor index wdata[11:5]. The pointer reads back as index<<5, with bits 4:0 always zero.
- R6: A hw_prod pulse advances the producer index by one, and a hw_cons pulse advances the consumer index by one. An index at length-1 wraps to 0. Both pulses may act in the same cycle.
- R7: q_empty is set when both indices are equal. q_full is set when the occupancy equals length-1. Occupancy is producer minus consumer when producer ≥ consumer, and length minus (consumer minus producer) otherwise.
- R8: A hw_prod pulse on a full queue is dropped and sets that queue's ovf_err. A hw_cons pulse on an empty queue is dropped and sets unf_err. Both flags hold until reset.
- R9: A software write to a pointer in the same cycle as a pulse on that pointer wins. The pulse is dropped and no error is flagged.
- R10: wr_desc_addr and rd_desc_addr of each queue equal its base address plus the producer or consumer byte offset, respectively.
- R11: Writes and pulses aimed at one queue leave every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address: queue select and offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| hw_prod | input | 4 | Per-queue producer advance pulse |
| hw_cons | input | 4 | Per-queue consumer advance pulse |
| q_empty | output | 4 | Per-queue empty flag |
| q_full | output | 4 | Per-queue full flag |
| ovf_err | output | 4 | Per-queue sticky overflow flag |
| unf_err | output | 4 | Per-queue sticky underflow flag |
| wr_desc_addr | output | 128 | Producer descriptor address, queue q at bits [q*32 +: 32] |
| rd_desc_addr | output | 128 | Consumer descriptor address, queue q at bits [q*32 +: 32] |

## Verification
The properties assume that every programmed length is at least 2 and that every index written by software lies below the length. Under a length of 1, a queue would be empty and full at once, and an advance would not move the address. The stimulus uses only lengths of 2, 4 and 64 and pointer values well inside them. Pulses are single-cycle, and the collision cases are driven on purpose so that software precedence is observed at the ports.

// File: rtl/ring_bank_pkg.sv
// Shared constants for the descriptor ring pointer bank.
// Assumes a 32-byte register window per queue and 32-byte descriptors.
package ring_bank_pkg;
    localparam logic [4:0] OFS_BASE   = 5'h00;
    localparam logic [4:0] OFS_LEN    = 5'h04;
    localparam logic [4:0] OFS_PROD   = 5'h08;
    localparam logic [4:0] OFS_CONS   = 5'h0C;
    localparam logic [4:0] OFS_PERMIT = 5'h18;

    localparam int PERMIT_BASE_BIT = 2;
    localparam int PERMIT_LEN_BIT  = 1;

    localparam int DESC_SHIFT = 5;   // bytes per descriptor = 32
    localparam int LEN_SHIFT  = 3;   // length exchanged as count * 8

    typedef enum logic [1:0] {
        RING_RX_FREE = 2'd0,
        RING_RX_DONE = 2'd1,
        RING_TX_POST = 2'd2,
        RING_TX_DONE = 2'd3
    } ring_id_e;
endpackage

// File: rtl/ring_occupancy.sv
// Occupancy arithmetic for one circular queue.
// Computes the used slot count, the empty and full flags, and the wrapped
// successor of each index. Assumes length >= 2 and both indices below it.
module ring_occupancy #(
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] prod_idx,
    input  logic [IDX_W-1:0] cons_idx,
    input  logic [IDX_W-1:0] len,
    output logic             empty,
    output logic             full,
    output logic [IDX_W-1:0] prod_next,
    output logic [IDX_W-1:0] cons_next
);
    logic [IDX_W-1:0] used;
    logic [IDX_W-1:0] last;

    // Last valid index of the ring.
    assign last = len - IDX_W'(1);

    // Used slots, with the producer ahead of or behind the consumer.
    always_comb begin
        if (prod_idx >= cons_idx) used = prod_idx - cons_idx;
        else                      used = len - (cons_idx - prod_idx);
    end

    assign empty = (prod_idx == cons_idx);
    assign full  = (used == last);

    // Wrapped successors of both indices.
    assign prod_next = (prod_idx >= last) ? '0 : prod_idx + IDX_W'(1);
    assign cons_next = (cons_idx >= last) ? '0 : cons_idx + IDX_W'(1);
endmodule

// File: rtl/ring_queue_regs.sv
// Register slice for one descriptor queue: base, length, two indices,
// permit bits and sticky error flags. Software writes to a pointer beat a
// hardware pulse on the same pointer in the same cycle. Assumes wr_sel is
// already qualified by the queue select.
module ring_queue_regs
    import ring_bank_pkg::*;
#(
    parameter int DW      = 32,
    parameter int IDX_W   = 7,
    parameter int RST_LEN = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sel,
    input  logic [4:0]    ofs,
    input  logic [DW-1:0] wdata,
    input  logic          prod_pulse,
    input  logic          cons_pulse,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic          ovf,
    output logic          unf,
    output logic [DW-1:0] prod_addr,
    output logic [DW-1:0] cons_addr
);
    logic [DW-1:0]    base_q;
    logic [IDX_W-1:0] len_q;
    logic [IDX_W-1:0] prod_q;
    logic [IDX_W-1:0] cons_q;
    logic             pm_base_q;
    logic             pm_len_q;
    logic             ovf_q;
    logic             unf_q;
    logic [IDX_W-1:0] prod_next;
    logic [IDX_W-1:0] cons_next;

    logic sw_base, sw_len, sw_prod, sw_cons, sw_permit;

    // Decode software writes, gating the guarded fields by their permit bits.
    assign sw_base   = wr_sel && (ofs == OFS_BASE) && pm_base_q;
    assign sw_len    = wr_sel && (ofs == OFS_LEN)  && pm_len_q;
    assign sw_prod   = wr_sel && (ofs == OFS_PROD);
    assign sw_cons   = wr_sel && (ofs == OFS_CONS);
    assign sw_permit = wr_sel && (ofs == OFS_PERMIT);

    ring_occupancy #(.IDX_W(IDX_W)) i_occ (
        .prod_idx  (prod_q),
        .cons_idx  (cons_q),
        .len       (len_q),
        .empty     (empty),
        .full      (full),
        .prod_next (prod_next),
        .cons_next (cons_next)
    );

    // Permit bits for the guarded fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_base_q <= 1'b0;
            pm_len_q  <= 1'b0;
        end else if (sw_permit) begin
            pm_base_q <= wdata[PERMIT_BASE_BIT];
            pm_len_q  <= wdata[PERMIT_LEN_BIT];
        end
    end

    // Ring base address.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (sw_base) base_q <= wdata;
    end

    // Ring length in descriptors.
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= IDX_W'(RST_LEN);
        else if (sw_len) len_q <= wdata[IDX_W+LEN_SHIFT-1:LEN_SHIFT];
    end

    // Producer index: software write first, then a pulse that fits.
    always_ff @(posedge clk) begin
        if (!rst_n)                  prod_q <= '0;
        else if (sw_prod)            prod_q <= wdata[IDX_W+DESC_SHIFT-1:DESC_SHIFT];
        else if (prod_pulse && !full) prod_q <= prod_next;
    end

    // Consumer index: software write first, then a pulse on a non-empty ring.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cons_q <= '0;
        else if (sw_cons)             cons_q <= wdata[IDX_W+DESC_SHIFT-1:DESC_SHIFT];
        else if (cons_pulse && !empty) cons_q <= cons_next;
    end

    // Sticky flags for dropped pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_q | (prod_pulse && full  && !sw_prod);
            unf_q <= unf_q | (cons_pulse && empty && !sw_cons);
        end
    end

    assign ovf = ovf_q;
    assign unf = unf_q;

    // Descriptor addresses for the DMA side.
    assign prod_addr = base_q + (DW'(prod_q) << DESC_SHIFT);
    assign cons_addr = base_q + (DW'(cons_q) << DESC_SHIFT);

    // Read-back of the register selected by the offset.
    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_BASE:   rdata = base_q;
            OFS_LEN:    rdata = DW'(len_q)  << LEN_SHIFT;
            OFS_PROD:   rdata = DW'(prod_q) << DESC_SHIFT;
            OFS_CONS:   rdata = DW'(cons_q) << DESC_SHIFT;
            OFS_PERMIT: begin
                rdata[PERMIT_BASE_BIT] = pm_base_q;
                rdata[PERMIT_LEN_BIT]  = pm_len_q;
            end
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/ring_rd_select.sv
// Selects the read data of the addressed queue from the flattened per-queue
// read data. A queue select with no matching queue returns zero.
module ring_rd_select #(
    parameter int NUM_Q  = 4,
    parameter int DW     = 32,
    parameter int QSEL_W = 2
) (
    input  logic [NUM_Q*DW-1:0] rdata_all,
    input  logic [QSEL_W-1:0]   qsel,
    output logic [DW-1:0]       rdata
);
    // One-of-N select by queue number.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (qsel == QSEL_W'(i)) rdata = rdata_all[i*DW +: DW];
        end
    end
endmodule

// File: rtl/ring_ptr_bank.sv
// Bank of descriptor ring pointer registers, one slice per queue.
// The first NUM_RX queues reset to RX_LEN descriptors and the rest reset to
// TX_LEN. Register reads are combinational and writes take effect at the
// clock edge. Assumes the hardware pulses are single-cycle strobes.
module ring_ptr_bank #(
    parameter  int NUM_Q   = 4,
    parameter  int NUM_RX  = 2,
    parameter  int DW      = 32,
    parameter  int RX_LEN  = 64,
    parameter  int TX_LEN  = 2,
    parameter  int MAX_LEN = 64,
    localparam int QSEL_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int ADDR_W  = QSEL_W + 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [NUM_Q-1:0]    hw_prod,
    input  logic [NUM_Q-1:0]    hw_cons,
    output logic [NUM_Q-1:0]    q_empty,
    output logic [NUM_Q-1:0]    q_full,
    output logic [NUM_Q-1:0]    ovf_err,
    output logic [NUM_Q-1:0]    unf_err,
    output logic [NUM_Q*DW-1:0] wr_desc_addr,
    output logic [NUM_Q*DW-1:0] rd_desc_addr
);
    localparam int IDX_W = $clog2(MAX_LEN + 1);

    logic [QSEL_W-1:0]   qsel;
    logic [4:0]          ofs;
    logic [NUM_Q*DW-1:0] rdata_all;

    // Split the byte address into queue select and register offset.
    assign qsel = reg_addr[ADDR_W-1:5];
    assign ofs  = reg_addr[4:0];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        localparam int RST_LEN = (q < NUM_RX) ? RX_LEN : TX_LEN;
        logic wr_sel;

        // Write strobe qualified by this queue's select.
        assign wr_sel = reg_wr && (qsel == QSEL_W'(q));

        ring_queue_regs #(
            .DW      (DW),
            .IDX_W   (IDX_W),
            .RST_LEN (RST_LEN)
        ) i_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (wr_sel),
            .ofs        (ofs),
            .wdata      (reg_wdata),
            .prod_pulse (hw_prod[q]),
            .cons_pulse (hw_cons[q]),
            .rdata      (rdata_all[q*DW +: DW]),
            .empty      (q_empty[q]),
            .full       (q_full[q]),
            .ovf        (ovf_err[q]),
            .unf        (unf_err[q]),
            .prod_addr  (wr_desc_addr[q*DW +: DW]),
            .cons_addr  (rd_desc_addr[q*DW +: DW])
        );
    end

    ring_rd_select #(
        .NUM_Q  (NUM_Q),
        .DW     (DW),
        .QSEL_W (QSEL_W)
    ) i_rdsel (
        .rdata_all (rdata_all),
        .qsel      (qsel),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/ring_ptr_bank_chk.sv
// Property checker for ring_ptr_bank, attached by bind. Assumes every
// programmed length is at least 2 and every software index lies below it.
module ring_ptr_bank_chk
    import ring_bank_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int DW     = 32,
    parameter int ADDR_W = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [NUM_Q-1:0]    hw_prod,
    input logic [NUM_Q-1:0]    hw_cons,
    input logic [NUM_Q-1:0]    q_empty,
    input logic [NUM_Q-1:0]    q_full,
    input logic [NUM_Q-1:0]    ovf_err,
    input logic [NUM_Q-1:0]    unf_err,
    input logic [NUM_Q*DW-1:0] wr_desc_addr,
    input logic [NUM_Q*DW-1:0] rd_desc_addr
);
    localparam int QSEL_W = ADDR_W - 5;

    // R1: leaving reset, all queues are empty and no flag is raised.
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (&q_empty && q_full == '0 && ovf_err == '0 && unf_err == '0));

    for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
        logic touch;
        logic sw_prod;
        assign touch   = reg_wr && (reg_addr[ADDR_W-1:5] == QSEL_W'(q));
        assign sw_prod = touch && (reg_addr[4:0] == OFS_PROD);

        // R7: empty and full never coincide.
        a_r7_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(q_empty[q] && q_full[q]));

        // R8: a producer pulse on a full ring is dropped and flagged.
        a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_prod[q] && q_full[q] && !touch)
            |=> (ovf_err[q] && $stable(wr_desc_addr[q*DW +: DW])));

        // R8: a consumer pulse on an empty ring is dropped and flagged.
        a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_cons[q] && q_empty[q] && !touch)
            |=> (unf_err[q] && $stable(rd_desc_addr[q*DW +: DW])));

        // R8: the error flags are sticky.
        a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_err[q] |=> ovf_err[q]);
        a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            unf_err[q] |=> unf_err[q]);

        // R6: a producer pulse that fits moves the producer address.
        a_r6_prod_moves: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_prod[q] && !q_full[q] && !touch)
            |=> !$stable(wr_desc_addr[q*DW +: DW]));

        // R6: a consumer pulse on a non-empty ring moves the consumer address.
        a_r6_cons_moves: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_cons[q] && !q_empty[q] && !touch)
            |=> !$stable(rd_desc_addr[q*DW +: DW]));

        // R9: a colliding software write leaves the overflow flag unchanged.
        a_r9_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_prod && hw_prod[q]) |=> $stable(ovf_err[q]));
    end
endmodule

bind ring_ptr_bank ring_ptr_bank_chk #(
    .NUM_Q  (NUM_Q),
    .DW     (DW),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .hw_prod      (hw_prod),
    .hw_cons      (hw_cons),
    .q_empty      (q_empty),
    .q_full       (q_full),
    .ovf_err      (ovf_err),
    .unf_err      (unf_err),
    .wr_desc_addr (wr_desc_addr),
    .rd_desc_addr (rd_desc_addr)
);

// File: tb/test_ring_ptr_bank.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them against the design outputs.
module test_ring_ptr_bank;
    import ring_bank_pkg::*;

    localparam int NQ = 4;
    localparam int DW = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [6:0]     reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic [DW-1:0]  reg_rdata;
    logic [NQ-1:0]  hw_prod = '0;
    logic [NQ-1:0]  hw_cons = '0;
    logic [NQ-1:0]  q_empty, q_full, ovf_err, unf_err;
    logic [NQ*DW-1:0] wr_desc_addr, rd_desc_addr;

    ring_ptr_bank i_ring_ptr_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_prod(hw_prod), .hw_cons(hw_cons),
        .q_empty(q_empty), .q_full(q_full), .ovf_err(ovf_err), .unf_err(unf_err),
        .wr_desc_addr(wr_desc_addr), .rd_desc_addr(rd_desc_addr)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Expected item: kind 0 = reg_rdata, 1 = empty, 2 = full, 3 = ovf,
    // 4 = unf, 5 = producer address, 6 = consumer address.
    typedef struct {
        int          kind;
        int          q;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event  sample_ev;

    // Reference model built from the requirements.
    logic [31:0] m_base[NQ];
    int          m_len[NQ];
    int          m_wi[NQ];
    int          m_ri[NQ];
    bit          m_pb[NQ];
    bit          m_pl[NQ];
    bit          m_ovf[NQ];
    bit          m_unf[NQ];

    function automatic int m_used(int i);
        if (m_wi[i] >= m_ri[i]) return m_wi[i] - m_ri[i];
        return m_len[i] - (m_ri[i] - m_wi[i]);
    endfunction
    function automatic bit m_full(int i);
        return m_used(i) == m_len[i] - 1;
    endfunction
    function automatic bit m_empty(int i);
        return m_wi[i] == m_ri[i];
    endfunction
    function automatic int m_next(int i, int x);
        return (x >= m_len[i] - 1) ? 0 : x + 1;
    endfunction

    // Monitor: compare every pending item shortly after each sample request.
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = reg_rdata;
                    1: act = 32'(q_empty);
                    2: act = 32'(q_full);
                    3: act = 32'(ovf_err);
                    4: act = 32'(unf_err);
                    5: act = wr_desc_addr[it.q*DW +: DW];
                    default: act = rd_desc_addr[it.q*DW +: DW];
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s q%0d kind%0d actual=%h expected=%h",
                             it.tag, it.q, it.kind, act, it.exp);
                end
            end
        end
    end

    // One clock of stimulus with the model updated from the pre-edge state.
    task automatic step(bit wr, int q, logic [4:0] ofs, logic [31:0] d,
                        logic [NQ-1:0] prod, logic [NQ-1:0] cons);
        @(negedge clk);
        reg_wr = wr; reg_addr = {2'(q), ofs}; reg_wdata = d;
        hw_prod = prod; hw_cons = cons;
        for (int i = 0; i < NQ; i++) begin
            bit f = m_full(i);
            bit e = m_empty(i);
            bit sw = wr && (q == i);
            int nw = m_wi[i];
            int nr = m_ri[i];
            if (sw && ofs == OFS_PROD) nw = int'(d[11:5]);
            else if (prod[i]) begin
                if (f) m_ovf[i] = 1; else nw = m_next(i, m_wi[i]);
            end
            if (sw && ofs == OFS_CONS) nr = int'(d[11:5]);
            else if (cons[i]) begin
                if (e) m_unf[i] = 1; else nr = m_next(i, m_ri[i]);
            end
            if (sw && ofs == OFS_BASE && m_pb[i]) m_base[i] = d;
            if (sw && ofs == OFS_LEN && m_pl[i]) m_len[i] = int'(d[9:3]);
            if (sw && ofs == OFS_PERMIT) begin
                m_pb[i] = d[2];
                m_pl[i] = d[1];
            end
            m_wi[i] = nw;
            m_ri[i] = nr;
        end
        @(negedge clk);
        reg_wr = 0; hw_prod = '0; hw_cons = '0;
    endtask

    task automatic wr_reg(int q, logic [4:0] ofs, logic [31:0] d);
        step(1, q, ofs, d, '0, '0);
    endtask

    task automatic push(int kind, int q, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.q = q; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic check_reg(int q, logic [4:0] ofs, logic [31:0] exp, string tag);
        reg_wr = 0;
        reg_addr = {2'(q), ofs};
        push(0, q, exp, tag);
        -> sample_ev;
        #2;
    endtask

    task automatic check_flags(string tag);
        logic [31:0] e, f, o, u;
        e = '0; f = '0; o = '0; u = '0;
        for (int i = 0; i < NQ; i++) begin
            e[i] = m_empty(i); f[i] = m_full(i); o[i] = m_ovf[i]; u[i] = m_unf[i];
        end
        push(1, 0, e, tag); push(2, 0, f, tag);
        push(3, 0, o, tag); push(4, 0, u, tag);
        -> sample_ev;
        #2;
    endtask

    task automatic check_all(int q, string tag);
        logic [31:0] pm;
        pm = {29'd0, m_pb[q], m_pl[q], 1'b0};
        check_reg(q, OFS_BASE, m_base[q], tag);
        check_reg(q, OFS_LEN, 32'(m_len[q]) << 3, tag);
        check_reg(q, OFS_PROD, 32'(m_wi[q]) << 5, tag);
        check_reg(q, OFS_CONS, 32'(m_ri[q]) << 5, tag);
        check_reg(q, OFS_PERMIT, pm, tag);
        push(5, q, m_base[q] + (32'(m_wi[q]) << 5), tag);
        push(6, q, m_base[q] + (32'(m_ri[q]) << 5), tag);
        check_flags(tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            m_base[i] = '0; m_len[i] = (i < 2) ? 64 : 2;
            m_wi[i] = 0; m_ri[i] = 0; m_pb[i] = 0; m_pl[i] = 0;
            m_ovf[i] = 0; m_unf[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset contents of every queue.
        for (int q = 0; q < NQ; q++) check_all(q, "R1");

        // R3: base write without permit is ignored, with permit lands.
        wr_reg(int'(RING_RX_FREE), OFS_BASE, 32'hDEAD_0000);
        check_reg(0, OFS_BASE, 32'h0, "R3");
        wr_reg(0, OFS_PERMIT, 32'h4);
        check_reg(0, OFS_PERMIT, 32'h4, "R2");
        wr_reg(0, OFS_BASE, 32'h1000_0000);
        check_reg(0, OFS_BASE, 32'h1000_0000, "R3");

        // R4: length guarded by permit bit 1 only.
        wr_reg(int'(RING_TX_POST), OFS_LEN, 32'h20);
        check_reg(2, OFS_LEN, 32'h10, "R4");
        wr_reg(2, OFS_PERMIT, 32'h4);
        wr_reg(2, OFS_LEN, 32'h20);
        check_reg(2, OFS_LEN, 32'h10, "R4");
        wr_reg(2, OFS_PERMIT, 32'h2);
        wr_reg(2, OFS_LEN, 32'h20);
        check_reg(2, OFS_LEN, 32'h20, "R4");
        wr_reg(2, OFS_PERMIT, 32'h0);
        check_all(2, "R4");

        // R5: pointer writes keep whole descriptors only.
        wr_reg(1, OFS_PROD, 32'h0000_041F);
        check_reg(1, OFS_PROD, 32'h400, "R5");
        check_all(1, "R5");
        wr_reg(1, OFS_PROD, 32'h0);
        check_all(1, "R5");

        // R6, R7: fill queue 2 (length 4) to full.
        for (int k = 0; k < 3; k++) begin
            step(0, 0, 5'h0, 0, 4'b0100, 4'b0000);
            check_all(2, "R7");
        end
        // R8: a further producer pulse is dropped and flagged.
        step(0, 0, 5'h0, 0, 4'b0100, 4'b0000);
        check_all(2, "R8");
        // R6: drain to empty, then wrap both indices.
        for (int k = 0; k < 3; k++) begin
            step(0, 0, 5'h0, 0, 4'b0000, 4'b0100);
            check_all(2, "R6");
        end
        step(0, 0, 5'h0, 0, 4'b0100, 4'b0000);
        check_all(2, "R6");
        step(0, 0, 5'h0, 0, 4'b0000, 4'b0100);
        check_all(2, "R6");

        // R8: underflow on queue 3 is dropped and sticky.
        step(0, 0, 5'h0, 0, 4'b0000, 4'b1000);
        check_all(3, "R8");
        step(0, 0, 5'h0, 0, 4'b0000, 4'b0000);
        check_flags("R8");

        // R6: both pulses on queue 0 in one cycle.
        step(0, 0, 5'h0, 0, 4'b0001, 4'b0000);
        step(0, 0, 5'h0, 0, 4'b0001, 4'b0001);
        check_all(0, "R6");

        // R9: software pointer writes beat colliding pulses.
        step(1, 0, OFS_PROD, 32'h100, 4'b0001, 4'b0000);
        check_all(0, "R9");
        step(1, 0, OFS_CONS, 32'h40, 4'b0000, 4'b0001);
        check_all(0, "R9");

        // R10: descriptor addresses follow a base change.
        wr_reg(0, OFS_BASE, 32'h2000_0040);
        check_all(0, "R10");

        // R2: an unmapped offset reads zero and is not written.
        wr_reg(0, 5'h10, 32'hFFFF_FFFF);
        check_reg(0, 5'h10, 32'h0, "R2");
        check_all(0, "R2");

        // R11: the other queues kept their own state.
        check_all(1, "R11");
        check_all(3, "R11");

        @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule